// File: doc/BRIEF.md
# Acquire/Release Ordering Gate

This block sits between one processor's in-order access stream and the memory system. It enforces the one-sided ordering rules of release consistency. Every access presented to the gate carries a kind: ordinary, acquire or release. The gate asserts an issue grant only when that kind may leave without breaking the rules. It watches completion pulses from memory, which are tagged with the same kinds, to learn what is still in flight.

An acquire blocks everything behind it until it completes, but it does not wait for the ordinary accesses ahead of it. A release waits until everything ahead of it has completed. Nothing behind a release waits for that release. A later access that needs to be ordered after a release must be protected by a later acquire. Ordinary accesses may overlap freely, and they may complete in any order.

Internally a three-state machine tracks the gate:

- `S_IDLE`: nothing in flight.
- `S_OPEN`: ordinary accesses in flight, no acquire.
- `S_HELD`: one acquire in flight.

A counter with a fixed ceiling holds the number of ordinary accesses in flight. The transitions are:

- *drain*: `S_OPEN` to `S_IDLE`, when the last ordinary access completes.
- *fill*: `S_IDLE` to `S_OPEN`, on an ordinary issue.
- *lock*: `S_IDLE` or `S_OPEN` to `S_HELD`, when an acquire issues.
- *unlock*: `S_HELD` to `S_IDLE` or `S_OPEN`, when the acquire completes, chosen by the counter.

The grant is a combinational function of the registered state and the current request. A completion therefore takes effect on the grant one cycle after its pulse.

Top module: `acq_rel_gate`

## Requirements
- R1: After reset nothing is in flight. With no request the grant is low, and the first request of kind ordinary, acquire or release is granted in the same cycle.
- R2: The grant is high only while `req_valid` is high and `req_kind` is one of ordinary (2'b00), acquire (2'b01) or release (2'b10). Kind 2'b11 is never granted.
- R3: While an acquire is in flight, no request of any kind is granted. This includes a second acquire.
- R4: An acquire request is granted whenever no acquire is in flight, however many ordinary accesses are in flight.
- R5: A release request is granted only when no ordinary access and no acquire is in flight.
- R6: An ordinary request is not delayed by any release that was granted earlier. Release completions have no effect on any later grant.
- R7: Each ordinary completion pulse (`cmp_kind` 2'b00) lowers the in-flight count by one, regardless of the order in which accesses complete. A waiting release is granted in the cycle after the pulse that brings the count to zero.
- R8: An ordinary request is stalled while `OUTST_MAX` ordinary accesses are in flight. It is granted again in the cycle after one of them completes.
- R9: An acquire completion pulse (`cmp_kind` 2'b01) frees the gate, and a held request is granted in the following cycle.
- R10: Stray completions are ignored. An ordinary completion with nothing counted, an acquire completion with no acquire in flight, and any completion of kind 2'b11 all leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is waiting at the head of the stream |
| req_kind | input | 2 | Kind of the waiting access: 00 ordinary, 01 acquire, 10 release |
| req_grant | output | 1 | The waiting access may issue in this cycle |
| cmp_valid | input | 1 | One access completed in memory in this cycle |
| cmp_kind | input | 2 | Kind of the completed access |

## Verification
A wrong count or state shows up at `req_grant` as an early or late grant, no later than the next release or acquire request that meets it.

- A count that is too high stalls a release forever.
- A count that is too low, or one that has wrapped, lets a release through while accesses are still in flight.
- A lost acquire flag lets requests pass while an acquire is in flight.

The bench holds each request until it is granted and compares the grant every cycle with a model built from the rules. A stale state is therefore reported in the first cycle in which it changes the grant.

// File: rtl/arg_pkg.sv
package arg_pkg;
    typedef enum logic [1:0] {
        K_ORD = 2'b00,
        K_ACQ = 2'b01,
        K_REL = 2'b10,
        K_RSV = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_OPEN = 2'b01,
        S_HELD = 2'b10
    } state_e;
endpackage

// File: rtl/arg_outst_count.sv
module arg_outst_count #(
    parameter int OUTST_MAX = 15,
    localparam int CW = $clog2(OUTST_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          zero,
    output logic          full,
    output logic          nxt_zero
);
    localparam logic [CW-1:0] LIMIT = CW'(OUTST_MAX);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt_nxt;
    logic          dec_ok;

    // a decrement with nothing counted is a stray pulse
    assign dec_ok = dec && (cnt != '0);

    always_comb begin
        unique case ({inc, dec_ok})
            2'b10:   cnt_nxt = cnt + ONE;
            2'b01:   cnt_nxt = cnt - ONE;
            default: cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    assign zero     = (cnt == '0);
    assign full     = (cnt == LIMIT);
    assign nxt_zero = (cnt_nxt == '0);
endmodule

// File: rtl/arg_issue_policy.sv
module arg_issue_policy
    import arg_pkg::*;
(
    input  state_e      state,
    input  logic        full,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    output logic        grant
);
    logic allow;

    always_comb begin
        unique case (kind_e'(req_kind))
            K_ORD:   allow = (state != S_HELD) && !full;
            K_ACQ:   allow = (state != S_HELD);
            K_REL:   allow = (state == S_IDLE);
            default: allow = 1'b0;
        endcase
    end

    assign grant = req_valid && allow;
endmodule

// File: rtl/acq_rel_gate.sv
module acq_rel_gate
    import arg_pkg::*;
#(
    parameter int OUTST_MAX = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       req_grant,
    input  logic       cmp_valid,
    input  logic [1:0] cmp_kind
);
    localparam int CW = $clog2(OUTST_MAX + 1);

    state_e        state, state_nxt;
    logic [CW-1:0] cnt;
    logic          cnt_zero, cnt_full, cnt_nxt_zero;
    logic          ord_issue, acq_issue, ord_done, acq_done;

    assign ord_issue = req_grant && (req_kind == K_ORD);
    assign acq_issue = req_grant && (req_kind == K_ACQ);
    assign ord_done  = cmp_valid && (cmp_kind == K_ORD);
    assign acq_done  = cmp_valid && (cmp_kind == K_ACQ);

    arg_outst_count #(.OUTST_MAX(OUTST_MAX)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ord_issue),
        .dec      (ord_done),
        .cnt      (cnt),
        .zero     (cnt_zero),
        .full     (cnt_full),
        .nxt_zero (cnt_nxt_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // transitions: fill, drain, lock, unlock
    always_comb begin
        unique case (state)
            S_HELD: begin
                if (acq_done) state_nxt = cnt_nxt_zero ? S_IDLE : S_OPEN;
                else          state_nxt = S_HELD;
            end
            S_IDLE, S_OPEN: begin
                if (acq_issue) state_nxt = S_HELD;
                else           state_nxt = cnt_nxt_zero ? S_IDLE : S_OPEN;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // output decision
    arg_issue_policy u_policy (
        .state     (state),
        .full      (cnt_full),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .grant     (req_grant)
    );

    logic unused_ok;
    assign unused_ok = cnt_zero ^ (|cnt);
endmodule

// File: rtl/arg_gate_chk.sv
module arg_gate_chk #(
    parameter int OUTST_MAX = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       req_grant,
    input logic       cmp_valid,
    input logic [1:0] cmp_kind
);
    localparam int CW = $clog2(OUTST_MAX + 1);
    localparam logic [CW-1:0] LIMIT = CW'(OUTST_MAX);

    logic [CW-1:0] c_cnt;
    logic          c_acq;

    // independent shadow of what is in flight, built from port traffic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_cnt <= '0;
            c_acq <= 1'b0;
        end else begin
            if ((req_grant && req_kind == 2'b00) &&
                !(cmp_valid && cmp_kind == 2'b00 && c_cnt != '0))
                c_cnt <= c_cnt + CW'(1);
            else if (!(req_grant && req_kind == 2'b00) &&
                     (cmp_valid && cmp_kind == 2'b00 && c_cnt != '0))
                c_cnt <= c_cnt - CW'(1);
            if (req_grant && req_kind == 2'b01)      c_acq <= 1'b1;
            else if (cmp_valid && cmp_kind == 2'b01) c_acq <= 1'b0;
        end
    end

    a_r2_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind == 2'b11) |-> !req_grant);

    a_r3_acq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        c_acq |-> !req_grant);

    a_r4_acq_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b01 && !c_acq) |-> req_grant);

    a_r5_rel_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && req_kind == 2'b10) |-> (c_cnt == '0 && !c_acq));

    a_r6_ord_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00 && !c_acq && c_cnt != LIMIT) |-> req_grant);

    a_r8_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cnt == LIMIT) |-> !(req_grant && req_kind == 2'b00));
endmodule

bind acq_rel_gate arg_gate_chk #(.OUTST_MAX(OUTST_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_grant (req_grant),
    .cmp_valid (cmp_valid),
    .cmp_kind  (cmp_kind)
);

// File: tb/acq_rel_gate_test.sv
module acq_rel_gate_test;
    localparam int MAXO = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic       req_grant;
    logic       cmp_valid = 1'b0;
    logic [1:0] cmp_kind = 2'b00;

    int  n_chk = 0;
    int  n_bad = 0;
    int  m_cnt = 0;
    bit  m_acq = 1'b0;
    int  cyc = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    acq_rel_gate #(.OUTST_MAX(MAXO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_grant(req_grant), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind)
    );

    function automatic bit exp_grant(bit v, logic [1:0] k);
        if (!v) return 1'b0;
        case (k)
            2'b00:   return !m_acq && (m_cnt < MAXO);
            2'b01:   return !m_acq;
            2'b10:   return !m_acq && (m_cnt == 0);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(bit v, logic [1:0] k);
        if (!v || k == 2'b11) return "R2";
        if (m_acq)            return "R3";
        case (k)
            2'b00:   return (m_cnt >= MAXO) ? "R8" : "R6";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit got, bit exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: grant=%0b expected=%0b (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // one cycle: drive at negedge, check, then update model for the edge
    task automatic step(bit v, logic [1:0] k, bit cv, logic [1:0] ck,
                        string tag, output bit g);
        bit e;
        @(negedge clk);
        req_valid = v; req_kind = k; cmp_valid = cv; cmp_kind = ck;
        #1;
        e = exp_grant(v, k);
        g = req_grant;
        check(g, e, (tag == "") ? tag_of(v, k) : tag);
        if (cv && ck == 2'b00 && m_cnt > 0) m_cnt--;
        if (e && k == 2'b00) m_cnt++;
        m_acq = (m_acq && !(cv && ck == 2'b01)) || (e && k == 2'b01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: cycles=%0d expected=below 100000", cyc);
            finish_run();
        end
    end

    initial begin
        bit g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(0, 2'b00, 0, 2'b00, "R1", g);
        step(1, 2'b10, 0, 2'b00, "R1", g);   // release with nothing in flight
        // R2: reserved kind
        step(1, 2'b11, 0, 2'b00, "R2", g);
        // three ordinaries then an acquire
        for (int i = 0; i < 3; i++) step(1, 2'b00, 0, 2'b00, "R6", g);
        step(1, 2'b01, 0, 2'b00, "R4", g);
        step(1, 2'b00, 0, 2'b00, "R3", g);
        step(1, 2'b10, 0, 2'b00, "R3", g);
        step(1, 2'b01, 1, 2'b00, "R3", g);   // second acquire held
        step(1, 2'b00, 1, 2'b01, "R9", g);   // acquire completes this cycle
        step(1, 2'b00, 0, 2'b00, "R9", g);   // granted next cycle
        // release waits for drain (count is 3)
        step(1, 2'b10, 1, 2'b00, "R5", g);
        step(1, 2'b10, 1, 2'b00, "R7", g);
        step(1, 2'b10, 1, 2'b00, "R7", g);   // last completion
        step(1, 2'b10, 0, 2'b00, "R7", g);   // granted now
        // ordinary after release, release never completes
        step(1, 2'b00, 1, 2'b10, "R6", g);
        step(1, 2'b00, 0, 2'b00, "R6", g);
        // fill to the cap
        while (m_cnt < MAXO) step(1, 2'b00, 0, 2'b00, "R8", g);
        step(1, 2'b00, 0, 2'b00, "R8", g);
        step(1, 2'b00, 1, 2'b00, "R8", g);
        step(1, 2'b00, 0, 2'b00, "R8", g);
        while (m_cnt > 0) step(0, 2'b00, 1, 2'b00, "R7", g);
        // R10: stray completions
        step(0, 2'b00, 1, 2'b00, "R10", g);
        step(0, 2'b00, 1, 2'b01, "R10", g);
        step(0, 2'b00, 1, 2'b11, "R10", g);
        step(1, 2'b10, 0, 2'b00, "R10", g);
        step(1, 2'b00, 0, 2'b00, "R10", g);
        // random traffic, request held until granted
        void'($urandom(32'd2024));
        begin
            logic [1:0] k = 2'b00;
            bit         v = 1'b0;
            for (int n = 0; n < 4000; n++) begin
                bit cv = 1'b0;
                logic [1:0] ck = 2'b00;
                if (!v) begin
                    v = ($urandom % 3) != 0;
                    case ($urandom % 10)
                        0, 1:    k = 2'b01;
                        2:       k = 2'b10;
                        3:       k = 2'b11;
                        default: k = 2'b00;
                    endcase
                end
                case ($urandom % 6)
                    0, 1, 2: if (m_cnt > 0) begin cv = 1'b1; ck = 2'b00; end
                    3:       if (m_acq) begin cv = 1'b1; ck = 2'b01; end
                    4:       begin cv = ($urandom % 2) == 1; ck = 2'($urandom % 4); end
                    default: ;
                endcase
                step(v, k, cv, ck, "", g);
                if (g || k == 2'b11) v = 1'b0;
            end
        end
        finish_run();
    end
endmodule